// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Line Controller

This block holds the line state, tags and data of a small direct-mapped write-back data cache, and keeps that cache coherent with its peers on a shared bus. Each line is Invalid, Shared or Exclusive. The processor side issues read and write requests and holds each one until `cpu_ready` pulses. Misses go through a request/grant handshake with a bus arbiter. Once the bus is granted, the controller issues a read miss, a write miss or a write-back. The line fill comes back over a one-cycle fill strobe.

A snoop port watches the miss commands that other caches issue. When a snooped miss hits a line held here, the controller drops its copy or downgrades it. If the line is dirty, it supplies the line on a separate intervention output, so that memory can abandon its own reply.

A write to a clean line is treated as a miss. A miss that is still waiting for the bus is thrown away when a snoop hits its line. The request is then evaluated again against the line's new state, so a line that a snoop has already written back is not written back twice.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_ready`, `bus_req`, `snp_wb_valid` are low with `bus_cmd` = 2'b00 (idle). The first access to any address is a miss.
- R2: A read to a line that is not present asserts `bus_req`. After the grant, it issues `bus_cmd` = 2'b01 (read miss) for one cycle with the line address {tag, index}. It then waits for `bus_fill_valid` and returns the addressed word; word w of a line sits at bits [w*DATA_W +: DATA_W]. The line becomes Shared.
- R3: A write to an Invalid line, or to a Shared line whose tag matches, issues `bus_cmd` = 2'b10 (write miss). The written word is merged into the filled line, the other words are kept from the fill, and the line becomes Exclusive.
- R4: A read hit in Shared or Exclusive, and a write hit in Exclusive, complete with no bus request and no bus command. `cpu_ready` is high in the cycle after the request is first sampled.
- R5: A miss that displaces an Exclusive line with a different tag first issues `bus_cmd` = 2'b11 (write-back) for one cycle. That command carries the victim's line address and its full line data. The read or write miss follows in the next cycle.
- R6: A snooped write miss (`snp_cmd` = 2'b10) to the address of a Shared line makes it Invalid. It produces no intervention.
- R7: A snooped read miss (2'b01) to an Exclusive line pulses `snp_wb_valid` one cycle later, with the line's address and data, and leaves the line Shared. A snooped write miss to an Exclusive line does the same and leaves it Invalid. Snooped write-backs (2'b11), snoops to other tags, and snooped read misses to Shared lines change nothing.
- R8: No bus command is issued without `bus_gnt`. While the controller waits for the grant, the line keeps its old tag, state and data and still answers snoops.
- R9: If a snoop hits the line of a miss that is waiting for the grant, the snoop is applied first and the CPU request is evaluated again from the new line state.
- R10: A snoop takes priority over a CPU request in the same cycle, and that request completes one cycle later. `cpu_ready` is a single-cycle pulse raised only when an access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, word offset} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Access complete (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Bus grant, held while `bus_req` is high |
| bus_cmd | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W-OFF_W | Line address of the command |
| bus_wdata | output | WORDS_PER_LINE*DATA_W | Line data of a write-back |
| bus_fill_valid | input | 1 | Line fill strobe |
| bus_fill_data | input | WORDS_PER_LINE*DATA_W | Line fill data |
| snp_valid | input | 1 | Snooped command from another cache |
| snp_cmd | input | 2 | Snooped command code, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W-OFF_W | Snooped line address |
| snp_wb_valid | output | 1 | Dirty-line intervention strobe |
| snp_wb_addr | output | ADDR_W-OFF_W | Line address of the intervention |
| snp_wb_data | output | WORDS_PER_LINE*DATA_W | Line data of the intervention |

## Verification
The assertions take for granted an arbiter that raises `bus_gnt` only while `bus_req` is high and that keeps snoops off the bus while this controller holds the grant. They also assume a CPU that keeps its request stable until `cpu_ready` and a single fill strobe per miss. The stimulus models that arbiter and fill responder directly, and it raises snoops only while the controller is idle or is held waiting with the grant withheld. The race cases are reached by withholding the grant on purpose while a snoop to the pending line goes by.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHR = 2'b01,
      LN_EXC = 2'b10
   } line_st_t;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'b00,
      BC_RDMISS = 2'b01,
      BC_WRMISS = 2'b10,
      BC_WBACK  = 2'b11
   } bus_cmd_t;

   typedef enum logic [2:0] {
      F_IDLE,
      F_ARB,
      F_WBACK,
      F_MISS,
      F_FILL,
      F_RESP
   } ctl_st_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int LINES      = 8,
   parameter int IDX_W      = 3,
   parameter int TAG_W      = 11,
   parameter int LINE_W     = 128,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_idx,
   output line_st_t          a_state,
   output logic [TAG_W-1:0]  a_tag,
   output logic [LINE_W-1:0] a_data,
   input  logic [IDX_W-1:0]  b_idx,
   output line_st_t          b_state,
   output logic [TAG_W-1:0]  b_tag,
   output logic [LINE_W-1:0] b_data,
   input  logic              w_we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [TAG_W-1:0]  w_tag,
   input  line_st_t          w_state,
   input  logic [LINE_W-1:0] w_data,
   input  logic              s_we,
   input  logic [IDX_W-1:0]  s_idx,
   input  line_st_t          s_state
);
   logic [LINES-1:0][1:0]        st_vec;
   logic [LINES-1:0][TAG_W-1:0]  tag_vec;
   logic [LINES-1:0][LINE_W-1:0] dat_vec;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [LINE_W-1:0] dat_r;
      logic              sel_w;
      logic              sel_s;

      assign sel_w = w_we && (w_idx == IDX_W'(i));
      assign sel_s = s_we && (s_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     st_r <= LN_INV;
         else if (sel_s) st_r <= s_state;
         else if (sel_w) st_r <= w_state;
      end

      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_r <= '0;
               dat_r <= '0;
            end else if (sel_w) begin
               tag_r <= w_tag;
               dat_r <= w_data;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (sel_w) begin
               tag_r <= w_tag;
               dat_r <= w_data;
            end
         end
      end

      assign st_vec[i]  = st_r;
      assign tag_vec[i] = tag_r;
      assign dat_vec[i] = dat_r;
   end

   assign a_state = line_st_t'(st_vec[a_idx]);
   assign a_tag   = tag_vec[a_idx];
   assign a_data  = dat_vec[a_idx];
   assign b_state = line_st_t'(st_vec[b_idx]);
   assign b_tag   = tag_vec[b_idx];
   assign b_data  = dat_vec[b_idx];

   AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_we && s_we && (w_idx == s_idx))); // R8
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import coh_pkg::*;
#(
   parameter int TAG_W  = 11,
   parameter int IDX_W  = 3,
   parameter int LINE_W = 128,
   parameter int LA_W   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  bus_cmd_t          snp_cmd,
   input  logic [LA_W-1:0]   snp_addr,
   output logic [IDX_W-1:0]  b_idx,
   input  line_st_t          b_state,
   input  logic [TAG_W-1:0]  b_tag,
   input  logic [LINE_W-1:0] b_data,
   output logic              hit,
   output logic              upd_we,
   output line_st_t          upd_state,
   output logic              wb_valid,
   output logic [LA_W-1:0]   wb_addr,
   output logic [LINE_W-1:0] wb_data
);
   logic [TAG_W-1:0] s_tag;
   logic             is_miss;
   logic             wb_d;

   assign b_idx   = snp_addr[IDX_W-1:0];
   assign s_tag   = snp_addr[LA_W-1:IDX_W];
   assign is_miss = snp_valid && (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS);
   assign hit     = is_miss && (b_state != LN_INV) && (b_tag == s_tag);
   assign wb_d    = hit && (b_state == LN_EXC);

   always_comb begin
      upd_we    = 1'b0;
      upd_state = LN_INV;
      if (hit) begin
         if (snp_cmd == BC_RDMISS) begin
            upd_we    = (b_state == LN_EXC);
            upd_state = LN_SHR;
         end else begin
            upd_we    = 1'b1;
            upd_state = LN_INV;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= wb_d;
         if (wb_d) begin
            wb_addr <= snp_addr;
            wb_data <= b_data;
         end
      end
   end

   AST_WB_AFTER_MISS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(snp_valid && (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS))); // R7
   AST_WB_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == BC_WBACK) |=> !wb_valid); // R7
endmodule

// File: rtl/coh_ctl_fsm.sv
module coh_ctl_fsm
   import coh_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int OFF_W  = 2,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 11,
   parameter int LINE_W = 128,
   parameter int LA_W   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output bus_cmd_t          bus_cmd,
   output logic [LA_W-1:0]   bus_addr,
   output logic [LINE_W-1:0] bus_wdata,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              snp_valid,
   input  logic              snp_hit,
   input  logic [IDX_W-1:0]  snp_idx,
   output logic [IDX_W-1:0]  a_idx,
   input  line_st_t          a_state,
   input  logic [TAG_W-1:0]  a_tag,
   input  logic [LINE_W-1:0] a_data,
   output logic              lw_we,
   output logic [IDX_W-1:0]  lw_idx,
   output logic [TAG_W-1:0]  lw_tag,
   output line_st_t          lw_state,
   output logic [LINE_W-1:0] lw_data
);
   ctl_st_t           cur, nxt;
   logic [TAG_W-1:0]  c_tag;
   logic [IDX_W-1:0]  c_idx;
   logic [OFF_W-1:0]  c_off;
   logic              tag_eq;
   logic [DATA_W-1:0] line_word, fill_word;
   logic [DATA_W-1:0] rdata_d;
   logic              rdata_we;

   function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                              input logic [OFF_W-1:0] off);
      logic [DATA_W-1:0] r;
      r = '0;
      for (int w = 0; w < WORDS; w++)
         if (OFF_W'(w) == off) r = ln[w*DATA_W +: DATA_W];
      return r;
   endfunction

   function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] ln,
                                               input logic [OFF_W-1:0] off,
                                               input logic [DATA_W-1:0] wd);
      logic [LINE_W-1:0] r;
      r = ln;
      for (int w = 0; w < WORDS; w++)
         if (OFF_W'(w) == off) r[w*DATA_W +: DATA_W] = wd;
      return r;
   endfunction

   assign c_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
   assign c_idx     = cpu_addr[OFF_W +: IDX_W];
   assign c_off     = cpu_addr[OFF_W-1:0];
   assign tag_eq    = (a_tag == c_tag);
   assign a_idx     = c_idx;
   assign lw_idx    = c_idx;
   assign lw_tag    = c_tag;
   assign line_word = pick(a_data, c_off);
   assign fill_word = pick(fill_data, c_off);

   always_comb begin
      nxt       = cur;
      bus_cmd   = BC_IDLE;
      bus_addr  = '0;
      bus_wdata = '0;
      lw_we     = 1'b0;
      lw_state  = LN_INV;
      lw_data   = a_data;
      rdata_we  = 1'b0;
      rdata_d   = line_word;
      case (cur)
         F_IDLE: begin
            if (cpu_req && !snp_valid) begin
               if (!cpu_we && (a_state != LN_INV) && tag_eq) begin
                  rdata_we = 1'b1;
                  nxt      = F_RESP;
               end else if (cpu_we && (a_state == LN_EXC) && tag_eq) begin
                  lw_we    = 1'b1;
                  lw_state = LN_EXC;
                  lw_data  = merge(a_data, c_off, cpu_wdata);
                  rdata_we = 1'b1;
                  rdata_d  = cpu_wdata;
                  nxt      = F_RESP;
               end else begin
                  nxt = F_ARB;
               end
            end
         end
         F_ARB: begin
            if (snp_hit && (snp_idx == c_idx))
               nxt = F_IDLE;
            else if (bus_gnt)
               nxt = ((a_state == LN_EXC) && !tag_eq) ? F_WBACK : F_MISS;
         end
         F_WBACK: begin
            bus_cmd   = BC_WBACK;
            bus_addr  = {a_tag, c_idx};
            bus_wdata = a_data;
            nxt       = F_MISS;
         end
         F_MISS: begin
            bus_cmd  = cpu_we ? BC_WRMISS : BC_RDMISS;
            bus_addr = {c_tag, c_idx};
            nxt      = F_FILL;
         end
         F_FILL: begin
            if (fill_valid) begin
               lw_we    = 1'b1;
               lw_state = cpu_we ? LN_EXC : LN_SHR;
               lw_data  = cpu_we ? merge(fill_data, c_off, cpu_wdata) : fill_data;
               rdata_we = 1'b1;
               rdata_d  = cpu_we ? cpu_wdata : fill_word;
               nxt      = F_RESP;
            end
         end
         F_RESP: nxt = F_IDLE;
         default: nxt = F_IDLE;
      endcase
   end

   assign bus_req   = (cur == F_ARB) || (cur == F_WBACK) || (cur == F_MISS) || (cur == F_FILL);
   assign cpu_ready = (cur == F_RESP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur       <= F_IDLE;
         cpu_rdata <= '0;
      end else begin
         cur <= nxt;
         if (rdata_we) cpu_rdata <= rdata_d;
      end
   end

   AST_CMD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != BC_IDLE) |-> bus_gnt); // R8
   AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == BC_WBACK) |=> (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS)); // R5
   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R10
   AST_SNOOP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur == F_IDLE) && snp_valid) |=> !cpu_ready); // R10
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 32,
   parameter int WORDS_PER_LINE = 4,
   parameter int LINES          = 8,
   parameter bit RESET_DATA     = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cpu_req,
   input  logic                             cpu_we,
   input  logic [ADDR_W-1:0]                cpu_addr,
   input  logic [DATA_W-1:0]                cpu_wdata,
   output logic                             cpu_ready,
   output logic [DATA_W-1:0]                cpu_rdata,
   output logic                             bus_req,
   input  logic                             bus_gnt,
   output logic [1:0]                       bus_cmd,
   output logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0] bus_addr,
   output logic [WORDS_PER_LINE*DATA_W-1:0] bus_wdata,
   input  logic                             bus_fill_valid,
   input  logic [WORDS_PER_LINE*DATA_W-1:0] bus_fill_data,
   input  logic                             snp_valid,
   input  logic [1:0]                       snp_cmd,
   input  logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0] snp_addr,
   output logic                             snp_wb_valid,
   output logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0] snp_wb_addr,
   output logic [WORDS_PER_LINE*DATA_W-1:0] snp_wb_data
);
   localparam int OFF_W  = $clog2(WORDS_PER_LINE);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int LA_W   = ADDR_W - OFF_W;
   localparam int LINE_W = WORDS_PER_LINE * DATA_W;

   if (WORDS_PER_LINE < 2 || (1 << OFF_W) != WORDS_PER_LINE) begin : g_bad_words
      $error("WORDS_PER_LINE must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   logic [IDX_W-1:0]  a_idx, b_idx;
   line_st_t          a_state, b_state;
   logic [TAG_W-1:0]  a_tag, b_tag;
   logic [LINE_W-1:0] a_data, b_data;
   logic              lw_we;
   logic [IDX_W-1:0]  lw_idx;
   logic [TAG_W-1:0]  lw_tag;
   line_st_t          lw_state;
   logic [LINE_W-1:0] lw_data;
   logic              s_hit, s_we;
   line_st_t          s_state;
   bus_cmd_t          cmd_o;

   coh_line_store #(
      .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .RESET_DATA(RESET_DATA)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
      .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
      .w_we(lw_we), .w_idx(lw_idx), .w_tag(lw_tag), .w_state(lw_state), .w_data(lw_data),
      .s_we(s_we), .s_idx(b_idx), .s_state(s_state)
   );

   coh_snoop_unit #(
      .TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .LA_W(LA_W)
   ) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)), .snp_addr(snp_addr),
      .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
      .hit(s_hit), .upd_we(s_we), .upd_state(s_state),
      .wb_valid(snp_wb_valid), .wb_addr(snp_wb_addr), .wb_data(snp_wb_data)
   );

   coh_ctl_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS_PER_LINE), .OFF_W(OFF_W),
      .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .LA_W(LA_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_o),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .fill_valid(bus_fill_valid), .fill_data(bus_fill_data),
      .snp_valid(snp_valid), .snp_hit(s_hit), .snp_idx(b_idx),
      .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
      .lw_we(lw_we), .lw_idx(lw_idx), .lw_tag(lw_tag), .lw_state(lw_state), .lw_data(lw_data)
   );

   assign bus_cmd = cmd_o;
endmodule

// File: tb/snoop_cache_ctrl_test.sv
`timescale 1ns/1ps
module snoop_cache_ctrl_test;
   localparam int ADDR_W = 16, DATA_W = 32, WORDS = 4, LINES = 8;
   localparam int LA_W = 14, LINE_W = 128;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic              cpu_ready;
   logic [DATA_W-1:0] cpu_rdata;
   logic              bus_req, bus_gnt = 1'b0;
   logic [1:0]        bus_cmd;
   logic [LA_W-1:0]   bus_addr;
   logic [LINE_W-1:0] bus_wdata;
   logic              fill_valid = 1'b0;
   logic [LINE_W-1:0] fill_data = '0;
   logic              snp_valid = 1'b0;
   logic [1:0]        snp_cmd = 2'b00;
   logic [LA_W-1:0]   snp_addr = '0;
   logic              snp_wb_valid;
   logic [LA_W-1:0]   snp_wb_addr;
   logic [LINE_W-1:0] snp_wb_data;

   snoop_cache_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_fill_valid(fill_valid), .bus_fill_data(fill_data),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_wb_valid(snp_wb_valid), .snp_wb_addr(snp_wb_addr), .snp_wb_data(snp_wb_data)
   );

   always #4 clk = ~clk;

   typedef struct {
      logic [1:0]        cmd;
      logic [LA_W-1:0]   addr;
      logic [LINE_W-1:0] data;
      string             req;
   } bus_item_t;
   typedef struct {
      bit          chk;
      logic [31:0] data;
      string       req;
   } cpu_item_t;
   typedef struct {
      logic [LA_W-1:0]   addr;
      logic [LINE_W-1:0] data;
      string             req;
   } wb_item_t;

   bus_item_t bus_q[$];
   cpu_item_t cpu_q[$];
   wb_item_t  wb_q[$];
   int        n_vec = 0, n_bad = 0;
   bit        gnt_block = 1'b0;
   bit        fill_pend = 1'b0;
   logic [LA_W-1:0] fill_la;

   localparam logic [10:0] T1 = 11'h011, T2 = 11'h022, T3 = 11'h033, T5 = 11'h055,
                           T6 = 11'h066, T7 = 11'h077, T9 = 11'h099;
   localparam logic [31:0] D1 = 32'hAAAA0001, D2 = 32'hBBBB0002, D3 = 32'hCCCC0003,
                           D4 = 32'hDDDD0004, D5 = 32'hEEEE0005, D6 = 32'h12340006;

   function automatic logic [LINE_W-1:0] pat(input logic [LA_W-1:0] la);
      logic [LINE_W-1:0] r;
      for (int w = 0; w < WORDS; w++)
         r[w*32 +: 32] = 32'hC0DE0000 ^ (32'(la) << 4) ^ 32'(w);
      return r;
   endfunction

   function automatic logic [LINE_W-1:0] put(input logic [LINE_W-1:0] ln, input int w,
                                             input logic [31:0] d);
      logic [LINE_W-1:0] r;
      r = ln;
      r[w*32 +: 32] = d;
      return r;
   endfunction

   function automatic logic [31:0] wd(input logic [LINE_W-1:0] ln, input int w);
      return ln[w*32 +: 32];
   endfunction

   function automatic logic [LA_W-1:0] la(input logic [10:0] t, input logic [2:0] i);
      return {t, i};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // arbiter and fill responder
   initial forever begin
      @(negedge clk);
      bus_gnt = bus_req && !gnt_block;
   end
   initial forever begin
      @(negedge clk);
      fill_valid = 1'b0;
      if (fill_pend) begin
         fill_valid = 1'b1;
         fill_data  = pat(fill_la);
         fill_pend  = 1'b0;
      end
      if (bus_cmd == 2'b01 || bus_cmd == 2'b10) begin
         fill_pend = 1'b1;
         fill_la   = bus_addr;
      end
   end

   // monitor: pops expected items as the design produces them
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (bus_cmd != 2'b00) begin
            check(bus_gnt == 1'b1, "R8", "command without grant", LINE_W'(bus_gnt), 1);
            if (bus_q.size() == 0) begin
               check(1'b0, "R4", "unexpected bus command", LINE_W'({bus_cmd, bus_addr}), 0);
            end else begin
               bus_item_t e;
               e = bus_q.pop_front();
               check({bus_cmd, bus_addr} == {e.cmd, e.addr}, e.req, "bus cmd/addr",
                     LINE_W'({bus_cmd, bus_addr}), LINE_W'({e.cmd, e.addr}));
               if (e.cmd == 2'b11)
                  check(bus_wdata == e.data, e.req, "write-back data", bus_wdata, e.data);
            end
         end
         if (cpu_ready) begin
            if (cpu_q.size() == 0) begin
               check(1'b0, "R10", "unexpected ready", 1, 0);
            end else begin
               cpu_item_t c;
               c = cpu_q.pop_front();
               if (c.chk) check(cpu_rdata == c.data, c.req, "read data",
                                LINE_W'(cpu_rdata), LINE_W'(c.data));
            end
         end
         if (snp_wb_valid) begin
            if (wb_q.size() == 0) begin
               check(1'b0, "R7", "unexpected intervention", LINE_W'(snp_wb_addr), 0);
            end else begin
               wb_item_t s;
               s = wb_q.pop_front();
               check(snp_wb_addr == s.addr, s.req, "intervention addr",
                     LINE_W'(snp_wb_addr), LINE_W'(s.addr));
               check(snp_wb_data == s.data, s.req, "intervention data", snp_wb_data, s.data);
            end
         end
      end
   end

   task automatic exp_bus(input logic [1:0] c, input logic [LA_W-1:0] a,
                          input logic [LINE_W-1:0] d, input string req);
      bus_q.push_back('{c, a, d, req});
   endtask
   task automatic exp_wb(input logic [LA_W-1:0] a, input logic [LINE_W-1:0] d, input string req);
      wb_q.push_back('{a, d, req});
   endtask

   task automatic start_req(input bit we, input logic [10:0] t, input logic [2:0] i,
                            input logic [1:0] o, input logic [31:0] d);
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = {t, i, o};
      cpu_wdata = d;
   endtask
   task automatic wait_ready();
      forever begin
         @(negedge clk);
         if (cpu_ready) break;
      end
      cpu_req = 1'b0;
   endtask
   task automatic access(input bit we, input logic [10:0] t, input logic [2:0] i,
                         input logic [1:0] o, input logic [31:0] d, input bit chk,
                         input logic [31:0] exp, input string req);
      cpu_q.push_back('{chk, exp, req});
      start_req(we, t, i, o, d);
      wait_ready();
   endtask
   task automatic snoop(input logic [1:0] c, input logic [LA_W-1:0] a);
      @(negedge clk);
      snp_valid = 1'b1;
      snp_cmd   = c;
      snp_addr  = a;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(cpu_ready == 1'b0, "R1", "ready after reset", LINE_W'(cpu_ready), 0);
      check(bus_req == 1'b0, "R1", "bus_req after reset", LINE_W'(bus_req), 0);
      check(bus_cmd == 2'b00, "R1", "bus_cmd after reset", LINE_W'(bus_cmd), 0);
      check(snp_wb_valid == 1'b0, "R1", "intervention after reset", LINE_W'(snp_wb_valid), 0);

      // R1 R2: first read misses, line filled Shared
      exp_bus(2'b01, la(T1, 0), '0, "R2");
      access(0, T1, 0, 1, 0, 1, wd(pat(la(T1, 0)), 1), "R2");
      access(0, T1, 0, 2, 0, 1, wd(pat(la(T1, 0)), 2), "R4");

      // R3: write to Shared line is a write miss, word merged
      exp_bus(2'b10, la(T1, 0), '0, "R3");
      access(1, T1, 0, 0, D1, 0, 0, "R3");
      access(0, T1, 0, 0, 0, 1, D1, "R3");
      access(1, T1, 0, 3, D2, 0, 0, "R4");
      access(0, T1, 0, 3, 0, 1, D2, "R4");
      access(0, T1, 0, 1, 0, 1, wd(pat(la(T1, 0)), 1), "R3");

      // R5: replacing a dirty line writes it back first
      exp_bus(2'b11, la(T1, 0), put(put(pat(la(T1, 0)), 0, D1), 3, D2), "R5");
      exp_bus(2'b01, la(T2, 0), '0, "R5");
      access(0, T2, 0, 0, 0, 1, wd(pat(la(T2, 0)), 0), "R5");

      // R7: snooped read miss on Exclusive supplies data, line becomes Shared
      exp_bus(2'b10, la(T3, 1), '0, "R3");
      access(1, T3, 1, 2, D3, 0, 0, "R3");
      exp_wb(la(T3, 1), put(pat(la(T3, 1)), 2, D3), "R7");
      snoop(2'b01, la(T3, 1));
      access(0, T3, 1, 2, 0, 1, D3, "R7");
      exp_bus(2'b10, la(T3, 1), '0, "R3");
      access(1, T3, 1, 2, D4, 0, 0, "R3");
      // R7: snooped write miss on Exclusive supplies data, line becomes Invalid
      exp_wb(la(T3, 1), put(pat(la(T3, 1)), 2, D4), "R7");
      snoop(2'b10, la(T3, 1));
      exp_bus(2'b01, la(T3, 1), '0, "R7");
      access(0, T3, 1, 0, 0, 1, wd(pat(la(T3, 1)), 0), "R7");

      // R6: snooped write miss invalidates a Shared line
      snoop(2'b10, la(T2, 0));
      exp_bus(2'b01, la(T2, 0), '0, "R6");
      access(0, T2, 0, 1, 0, 1, wd(pat(la(T2, 0)), 1), "R6");

      // R7: ignored snoops leave the Shared line in place
      snoop(2'b11, la(T2, 0));
      snoop(2'b01, la(T5, 0));
      snoop(2'b10, la(T5, 0));
      snoop(2'b01, la(T2, 0));
      access(0, T2, 0, 2, 0, 1, wd(pat(la(T2, 0)), 2), "R7");

      // R4: hit latency is one cycle
      cpu_q.push_back('{1'b1, wd(pat(la(T2, 0)), 3), "R4"});
      start_req(0, T2, 0, 3, 0);
      @(negedge clk);
      check(cpu_ready == 1'b1, "R4", "hit ready latency", LINE_W'(cpu_ready), 1);
      cpu_req = 1'b0;

      // R10: snoop in the same cycle stalls the CPU by one cycle
      cpu_q.push_back('{1'b1, wd(pat(la(T2, 0)), 0), "R10"});
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = 1'b0;
      cpu_addr  = {T2, 3'd0, 2'd0};
      snp_valid = 1'b1;
      snp_cmd   = 2'b01;
      snp_addr  = la(T9, 5);
      @(negedge clk);
      snp_valid = 1'b0;
      check(cpu_ready == 1'b0, "R10", "ready during snoop stall", LINE_W'(cpu_ready), 0);
      @(negedge clk);
      check(cpu_ready == 1'b1, "R10", "ready after snoop stall", LINE_W'(cpu_ready), 1);
      cpu_req = 1'b0;

      // R9 R8: pending read loses the race to a snoop on its dirty victim
      exp_bus(2'b10, la(T6, 2), '0, "R3");
      access(1, T6, 2, 1, D5, 0, 0, "R3");
      gnt_block = 1'b1;
      exp_wb(la(T6, 2), put(pat(la(T6, 2)), 1, D5), "R8");
      exp_bus(2'b01, la(T7, 2), '0, "R9");
      cpu_q.push_back('{1'b1, wd(pat(la(T7, 2)), 0), "R9"});
      start_req(0, T7, 2, 0, 0);
      repeat (3) @(negedge clk);
      check(bus_req == 1'b1, "R8", "waiting for grant", LINE_W'(bus_req), 1);
      snoop(2'b01, la(T6, 2));
      repeat (2) @(negedge clk);
      gnt_block = 1'b0;
      wait_ready();

      // R9: pending write on a Shared line restarts after a snooped invalidate
      gnt_block = 1'b1;
      exp_bus(2'b10, la(T3, 1), '0, "R9");
      cpu_q.push_back('{1'b0, 0, "R9"});
      start_req(1, T3, 1, 1, D6);
      repeat (2) @(negedge clk);
      snoop(2'b10, la(T3, 1));
      @(negedge clk);
      gnt_block = 1'b0;
      wait_ready();
      access(0, T3, 1, 1, 0, 1, D6, "R9");

      repeat (4) @(negedge clk);
      check(bus_q.size() == 0, "R2", "bus commands missing", LINE_W'(bus_q.size()), 0);
      check(cpu_q.size() == 0, "R10", "responses missing", LINE_W'(cpu_q.size()), 0);
      check(wb_q.size() == 0, "R7", "interventions missing", LINE_W'(wb_q.size()), 0);
      finish_run();
   end
endmodule